// File: doc/BRIEF.md
# Interrupt Vector Table Relocator

This block forms the address from which the CPU fetches an interrupt or reset vector. It has one control register with a relocation bit. When the bit is clear, vectors come from the fixed table whose top word sits at the top of program memory. When the bit is set, the same table sits instead at the highest word of on-chip RAM. That address is a parameter, so a RAM built from several sections is described by the single top address of the whole space.

The CPU opens a fetch by pulsing `fetchStart` with a vector index. One cycle later the block presents the address on `vecAddr` with `vecValid` high. It holds that address until `fetchDone` closes the fetch. The table choice is captured when the fetch opens. A write to the control register during a fetch therefore changes only the next fetch.

Two resets act on the block. A brown-out reset clears everything, including the relocation bit, so the first fetch after it uses the default reset vector at 0xFFFE. The milder synchronous reset only abandons a fetch in flight and leaves the bit alone.

Top module: `vec_reloc_top`

## Requirements
- R1: While `borRstN` is low and after it rises, `vecValid` is 0, `vecAddr` is `ROM_TOP` (default 0xFFFE) and `regRdData` is 0.
- R2: A write with `regWrEn` = 1 and `regByteEn[0]` = 1 loads `regWrData[0]` into the relocation bit, which reads back on `regRdData[0]` from the next cycle.
- R3: A write with `regByteEn[0]` = 0, such as a high-byte-only write, leaves the relocation bit unchanged. `regRdData[15:1]` always reads 0.
- R4: With the relocation bit clear, a `fetchStart` accepted while idle gives `vecValid` = 1 and `vecAddr` = `ROM_TOP` − 2·`fetchIdx` on the next cycle.
- R5: With the relocation bit set, an accepted fetch gives `vecAddr` = `RAM_TOP` − 2·`fetchIdx`, so index 0 maps to `RAM_TOP` itself.
- R6: The table choice is sampled from the register value in the cycle the fetch starts. A write during an open fetch leaves `vecAddr` unchanged and takes effect at the next fetch.
- R7: `fetchDone` while `vecValid` is 1 drops `vecValid` on the next cycle, and `vecAddr` keeps its last value.
- R8: `fetchStart` while a fetch is open is ignored: `vecValid` stays 1 and `vecAddr` is unchanged.
- R9: `softRst` drops `vecValid` on the next cycle and leaves the relocation bit at its current value.
- R10: `RAM_TOP` must be word-aligned (bit 0 equal to 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| borRstN | input | 1 | Brown-out reset, asynchronous, active low; clears all state |
| softRst | input | 1 | Milder synchronous reset; aborts a fetch, keeps the relocation bit |
| regWrEn | input | 1 | Control register write strobe |
| regByteEn | input | 2 | Byte enables; bit 0 covers the byte holding the relocation bit |
| regWrData | input | 16 | Write data; bit 0 is the relocation bit |
| regRdData | output | 16 | Control register read value |
| fetchStart | input | 1 | Opens a vector fetch |
| fetchIdx | input | IDX_W | Vector index; 0 is the reset vector |
| fetchDone | input | 1 | Closes the open fetch |
| vecValid | output | 1 | A fetch is open and `vecAddr` is valid |
| vecAddr | output | ADDR_W | Vector word address |

## Verification
A relocation bit that is wrong inside the block shows up at `regRdData[0]` on the cycle after the write. It also shows up at the table base of the first fetch opened after that. A fetch-state register stuck open or closed shows at `vecValid` one cycle after `fetchStart`, `fetchDone` or `softRst`. A table choice that is not latched shows as `vecAddr` moving during an open fetch, in the cycle right after the offending write. The reference model is compared on every clock, so each of these faults is seen within one or two cycles of the stimulus that exposes it.

// File: rtl/vec_reloc_pkg.sv
package vec_reloc_pkg;

  typedef enum logic [0:0] {
    FETCH_IDLE = 1'b0,
    FETCH_OPEN = 1'b1
  } fetchState_t;

  typedef struct packed {
    logic loadAddr;
    logic useRam;
  } ctrlStrobes_t;

endpackage

// File: rtl/vec_reloc_ctrl.sv
module vec_reloc_ctrl
  import vec_reloc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              borRstN,
  input  logic              softRst,
  input  logic              regWrEn,
  input  logic [DATA_W/8-1:0] regByteEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              fetchStart,
  input  logic              fetchDone,
  output logic              fetchOpen,
  output ctrlStrobes_t      strobes
);

  logic        remapBit;
  fetchState_t state, stateNext;
  logic        acceptStart;

  // Relocation bit: only the lowest byte lane can touch it; brown-out clears it.
  always_ff @(posedge clk or negedge borRstN) begin
    if (!borRstN) begin
      remapBit <= 1'b0;
    end else if (regWrEn && regByteEn[0]) begin
      remapBit <= regWrData[0];
    end
  end

  assign regRdData = {{(DATA_W-1){1'b0}}, remapBit};

  assign acceptStart = (state == FETCH_IDLE) && fetchStart && !softRst;

  always_comb begin
    stateNext = state;
    if (softRst) begin
      stateNext = FETCH_IDLE;
    end else begin
      unique case (state)
        FETCH_IDLE: if (fetchStart) stateNext = FETCH_OPEN;
        FETCH_OPEN: if (fetchDone)  stateNext = FETCH_IDLE;
        default:    stateNext = FETCH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge borRstN) begin
    if (!borRstN) state <= FETCH_IDLE;
    else          state <= stateNext;
  end

  assign fetchOpen        = (state == FETCH_OPEN);
  assign strobes.loadAddr = acceptStart;
  assign strobes.useRam   = remapBit;

endmodule

// File: rtl/vec_reloc_dp.sv
module vec_reloc_dp
  import vec_reloc_pkg::*;
#(
  parameter int              ADDR_W  = 16,
  parameter int              IDX_W   = 6,
  parameter logic [ADDR_W-1:0] ROM_TOP = 16'hFFFE,
  parameter logic [ADDR_W-1:0] RAM_TOP = 16'h23FE
) (
  input  logic              clk,
  input  logic              borRstN,
  input  ctrlStrobes_t      strobes,
  input  logic [IDX_W-1:0]  fetchIdx,
  output logic [ADDR_W-1:0] vecAddr
);

  localparam int PAD_W = ADDR_W - IDX_W - 1;

  logic [ADDR_W-1:0] tableTop;
  logic [ADDR_W-1:0] byteOffset;
  logic [ADDR_W-1:0] nextAddr;

  assign tableTop = strobes.useRam ? RAM_TOP : ROM_TOP;

  generate
    if (PAD_W > 0) begin : g_pad
      assign byteOffset = {{PAD_W{1'b0}}, fetchIdx, 1'b0};
    end else begin : g_trunc
      assign byteOffset = ADDR_W'({fetchIdx, 1'b0});
    end
  endgenerate

  assign nextAddr = tableTop - byteOffset;

  always_ff @(posedge clk or negedge borRstN) begin
    if (!borRstN)              vecAddr <= ROM_TOP;
    else if (strobes.loadAddr) vecAddr <= nextAddr;
  end

endmodule

// File: rtl/vec_reloc_top.sv
module vec_reloc_top
  import vec_reloc_pkg::*;
#(
  parameter int              ADDR_W  = 16,
  parameter int              IDX_W   = 6,
  parameter logic [ADDR_W-1:0] ROM_TOP = 16'hFFFE,
  parameter logic [ADDR_W-1:0] RAM_TOP = 16'h23FE
) (
  input  logic              clk,
  input  logic              borRstN,
  input  logic              softRst,
  input  logic              regWrEn,
  input  logic [1:0]        regByteEn,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  input  logic              fetchStart,
  input  logic [IDX_W-1:0]  fetchIdx,
  input  logic              fetchDone,
  output logic              vecValid,
  output logic [ADDR_W-1:0] vecAddr
);

  ctrlStrobes_t strobes;

  vec_reloc_ctrl #(.DATA_W(16)) u_ctrl (
    .clk        (clk),
    .borRstN    (borRstN),
    .softRst    (softRst),
    .regWrEn    (regWrEn),
    .regByteEn  (regByteEn),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .fetchStart (fetchStart),
    .fetchDone  (fetchDone),
    .fetchOpen  (vecValid),
    .strobes    (strobes)
  );

  vec_reloc_dp #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .ROM_TOP(ROM_TOP),
    .RAM_TOP(RAM_TOP)
  ) u_dp (
    .clk      (clk),
    .borRstN  (borRstN),
    .strobes  (strobes),
    .fetchIdx (fetchIdx),
    .vecAddr  (vecAddr)
  );

endmodule

// File: rtl/vec_reloc_checker.sv
module vec_reloc_checker #(
  parameter int              ADDR_W  = 16,
  parameter int              IDX_W   = 6,
  parameter logic [ADDR_W-1:0] ROM_TOP = 16'hFFFE,
  parameter logic [ADDR_W-1:0] RAM_TOP = 16'h23FE
) (
  input logic              clk,
  input logic              borRstN,
  input logic              softRst,
  input logic              regWrEn,
  input logic [1:0]        regByteEn,
  input logic [15:0]       regRdData,
  input logic              fetchStart,
  input logic [IDX_W-1:0]  fetchIdx,
  input logic              fetchDone,
  input logic              vecValid,
  input logic [ADDR_W-1:0] vecAddr
);

  initial begin
    p_ram_top_even_r10: assert (RAM_TOP[0] == 1'b0)
      else $error("RAM_TOP must be word-aligned");
  end

  // R3: upper control bits never read as 1
  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!borRstN)
    regRdData[15:1] == '0);

  // R3: a write that skips byte lane 0 leaves the bit alone
  p_high_byte_r3: assert property (@(posedge clk) disable iff (!borRstN)
    (regWrEn && !regByteEn[0]) |=> $stable(regRdData[0]));

  // R4: an idle start opens a fetch next cycle
  p_open_r4: assert property (@(posedge clk) disable iff (!borRstN)
    (fetchStart && !vecValid && !softRst) |=> vecValid);

  // R5: index 0 lands on one of the two table tops
  p_top_word_r5: assert property (@(posedge clk) disable iff (!borRstN)
    (fetchStart && !vecValid && !softRst && fetchIdx == '0)
      |=> (vecAddr == ROM_TOP || vecAddr == RAM_TOP));

  // R6/R8: the address is frozen while a fetch stays open
  p_hold_r6: assert property (@(posedge clk) disable iff (!borRstN)
    (vecValid && !fetchDone && !softRst) |=> (vecValid && $stable(vecAddr)));

  // R7: done closes the fetch
  p_close_r7: assert property (@(posedge clk) disable iff (!borRstN)
    (vecValid && fetchDone && !softRst) |=> !vecValid);

  // R9: mild reset aborts the fetch and keeps the bit
  p_soft_keep_r9: assert property (@(posedge clk) disable iff (!borRstN)
    (softRst && !regWrEn) |=> (!vecValid && $stable(regRdData[0])));

endmodule

bind vec_reloc_top vec_reloc_checker #(
  .ADDR_W (ADDR_W),
  .IDX_W  (IDX_W),
  .ROM_TOP(ROM_TOP),
  .RAM_TOP(RAM_TOP)
) u_checker (
  .clk        (clk),
  .borRstN    (borRstN),
  .softRst    (softRst),
  .regWrEn    (regWrEn),
  .regByteEn  (regByteEn),
  .regRdData  (regRdData),
  .fetchStart (fetchStart),
  .fetchIdx   (fetchIdx),
  .fetchDone  (fetchDone),
  .vecValid   (vecValid),
  .vecAddr    (vecAddr)
);

// File: tb/vec_reloc_top_test.sv
module vec_reloc_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 6;
  localparam logic [15:0] ROM_TOP = 16'hFFFE;
  localparam logic [15:0] RAM_TOP = 16'h23FE;

  logic clk = 1'b0;
  logic borRstN = 1'b0;
  logic softRst = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regByteEn = 2'b00;
  logic [15:0] regWrData = 16'h0000;
  logic [15:0] regRdData;
  logic fetchStart = 1'b0;
  logic [IDX_W-1:0] fetchIdx = '0;
  logic fetchDone = 1'b0;
  logic vecValid;
  logic [15:0] vecAddr;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // behavioural reference
  bit mRemap = 0;
  bit mOpen = 0;
  int mAddr = 'hFFFE;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_reloc_top #(.ADDR_W(16), .IDX_W(IDX_W), .ROM_TOP(ROM_TOP), .RAM_TOP(RAM_TOP)) uut (
    .clk(clk), .borRstN(borRstN), .softRst(softRst),
    .regWrEn(regWrEn), .regByteEn(regByteEn), .regWrData(regWrData),
    .regRdData(regRdData), .fetchStart(fetchStart), .fetchIdx(fetchIdx),
    .fetchDone(fetchDone), .vecValid(vecValid), .vecAddr(vecAddr)
  );

  always @(posedge clk or negedge borRstN) begin
    if (!borRstN) begin
      mRemap = 0; mOpen = 0; mAddr = 'hFFFE;
    end else begin
      bit oldRemap;
      oldRemap = mRemap;
      if (regWrEn && regByteEn[0]) mRemap = regWrData[0];
      if (softRst) mOpen = 0;
      else if (!mOpen && fetchStart) begin
        mOpen = 1;
        mAddr = ((oldRemap ? 'h23FE : 'hFFFE) - 2 * int'(fetchIdx)) & 'hFFFF;
      end else if (mOpen && fetchDone) mOpen = 0;
    end
  end

  task automatic check(input string req);
    compared++;
    if (vecValid !== mOpen || int'(vecAddr) != mAddr || regRdData !== {15'b0, mRemap}) begin
      mismatched++;
      $display("FAIL %s: actual valid=%0b addr=%h rd=%h expected valid=%0b addr=%h rd=%h",
               req, vecValid, vecAddr, regRdData, mOpen, mAddr[15:0], {15'b0, mRemap});
    end
  endtask

  task automatic step(input string req);
    @(posedge clk);
    @(negedge clk);
    check(req);
    regWrEn = 0; regByteEn = 2'b00; fetchStart = 0; fetchDone = 0; softRst = 0;
  endtask

  task automatic wr(input logic [1:0] be, input logic [15:0] d);
    regWrEn = 1; regByteEn = be; regWrData = d;
  endtask

  task automatic start(input int idx);
    fetchStart = 1; fetchIdx = IDX_W'(idx);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  initial begin
    #1;
    @(negedge clk);
    check("R1 in reset");
    @(negedge clk);
    borRstN = 1;
    step("R1 after reset");

    // R4: default table
    start(0);          step("R4 idx0 rom");
    fetchDone = 1;     step("R7 close");
    start(5);          step("R4 idx5 rom");
    start(9);          step("R8 start ignored");
    fetchDone = 1;     step("R7 close addr held");
    step("R7 idle hold");

    // R2 / R3 register
    wr(2'b10, 16'hFFFF); step("R3 high byte only");
    wr(2'b01, 16'h0001); step("R2 set bit");
    wr(2'b10, 16'h0000); step("R3 high byte clear ignored");

    // R5 relocated
    start(0);          step("R5 idx0 ram top");
    fetchDone = 1;     step("R7 close ram");
    start(63);         step("R5 idx63 ram");

    // R6 write during open fetch
    wr(2'b11, 16'h0000); step("R6 write during fetch");
    step("R6 still held");
    fetchDone = 1;     step("R7 close");
    start(1);          step("R6 next fetch uses rom");
    fetchDone = 1;     step("R7 close");

    // R6 write in same cycle as start uses old value
    wr(2'b01, 16'h0001); start(2); step("R6 start samples old value");
    fetchDone = 1;     step("R7 close");
    start(2);          step("R5 idx2 ram");

    // R9 soft reset keeps bit, aborts fetch
    softRst = 1;       step("R9 soft abort keeps bit");
    start(3); softRst = 1; step("R9 soft blocks start");
    start(4);          step("R5 after soft");

    // R1 brown-out clears bit
    @(negedge clk);
    borRstN = 0;
    #1;
    mRemap = 0; mOpen = 0; mAddr = 'hFFFE;
    check("R1 brown-out clears");
    @(negedge clk);
    borRstN = 1;
    step("R1 after brown-out");
    start(0);          step("R1 first fetch default 0xFFFE");
    fetchDone = 1;     step("R7 close");

    // R10 word alignment of the RAM table top
    compared++;
    if (RAM_TOP[0] !== 1'b0) begin
      mismatched++;
      $display("FAIL R10: actual lsb=%0b expected 0", RAM_TOP[0]);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule